// File: doc/BRIEF.md
# SPI FIFO Status and Request Logic

This block holds the transmit and receive word queues that sit between software (or a DMA engine) and a serial shifting engine, and turns their state into sticky status flags and request lines. Software pushes words into the transmit queue and pops them from the receive queue. The serial engine pulls words from the transmit queue, delivers received words into the receive queue and reports the end of each frame. Serial timing is not part of this block.

Six sticky flags record receive-data-present, receive overflow, transmit-space-available, transmit underflow, end-of-queue and frame-done events. Each flag is cleared by writing a 1 to its bit through a small register write port. A control register on the same port holds a request enable per flag and the receive overwrite policy. It also holds bits that cut either queue down to a single entry and bits that steer the drain and fill requests to DMA request lines instead of the interrupt. Two more bits of that register are one-shot flush commands for the queues.

Top module: `spi_fifo_status`

## Requirements
- R1: Out of reset all flags are 0, `irq`, `dma_drain_req` and `dma_fill_req` are 0, and `rx_count` and `tx_count` are 0. The counts then give the number of stored words, from 0 up to DEPTH (4).
- R2: Each queue returns words in the order they were accepted. `rx_pop_data` and `tx_pop_data` always show the oldest stored word.
- R3: Flag bit 0 (drain) is set on the clock edge after `rx_count` is nonzero. Flag bit 2 (fill) is set on each edge where `tx_count` is below the transmit capacity. Both stay set until cleared.
- R4: A write with `reg_sel`=0 clears every flag whose `reg_wdata` bit is 1 and leaves the others alone. If a flag's set condition holds in the same cycle, the flag stays 1.
- R5: A receive push while the receive queue is full and not being popped sets flag bit 1 (overflow) on that edge. With overwrite off, the word is dropped and the count stays at capacity.
- R6: With control bit 8 (overwrite) at 1, the word that overflows replaces the most recently written entry, so it is read out last.
- R7: A transmit pop while the transmit queue is empty sets flag bit 3 (underflow) on that edge, and `tx_count` stays 0.
- R8: `frame_done` sets flag bit 5 (frame done) on that edge. Flag bit 4 (end of queue) is set only when `frame_eoq` is also 1.
- R9: A write with `reg_sel`=1 loads `reg_wdata[10:0]` into the control register. The same write with bit 11 at 1 empties the receive queue, and with bit 12 at 1 empties the transmit queue, both at that edge.
- R10: Control bit 9 limits the receive queue to one entry and control bit 10 limits the transmit queue to one entry. Further receive pushes then overflow.
- R11: Control bits 5:0 enable the requests of flags 5:0. A flag drives a request only when its enable bit is 1. `irq` is the OR of the enabled flags that are not steered to a DMA line.
- R12: Control bit 6 steers the enabled drain request from `irq` to `dma_drain_req`. Control bit 7 steers the enabled fill request from `irq` to `dma_fill_req`. A DMA line is 0 while its steer bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Software writes a word into the transmit queue |
| tx_push_data | input | DW (16) | Word to transmit |
| tx_pop | input | 1 | Serial engine takes the oldest transmit word |
| tx_pop_data | output | DW (16) | Oldest transmit word |
| rx_push | input | 1 | Serial engine delivers a received word |
| rx_push_data | input | DW (16) | Received word |
| rx_pop | input | 1 | Software reads the oldest received word |
| rx_pop_data | output | DW (16) | Oldest received word |
| frame_done | input | 1 | Serial engine finished a frame |
| frame_eoq | input | 1 | The finished frame was the last of a queue |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: flag clear write, 1: control write |
| reg_wdata | input | 16 | Register write data |
| flags | output | 6 | Sticky flags: 0 drain, 1 rx overflow, 2 fill, 3 tx underflow, 4 end of queue, 5 frame done |
| rx_count | output | CNT_W (4) | Words in the receive queue |
| tx_count | output | CNT_W (4) | Words in the transmit queue |
| irq | output | 1 | Interrupt request |
| dma_drain_req | output | 1 | DMA request to read the receive queue |
| dma_fill_req | output | 1 | DMA request to write the transmit queue |

## Verification
A wrong read or write pointer shows up on `rx_pop_data` or `tx_pop_data` at the first pop after it goes wrong. A wrong occupancy count shows up at once on `rx_count` or `tx_count`. It also shows up one edge later as a missing or spurious drain, fill or overflow flag. A wrong control bit changes `irq` or a DMA request line in the cycle after the write, so the bench reads every control write back through the request outputs. The overwrite and single-entry modes are each run up to the point of overflow and then drained in full, so a word put in the wrong slot cannot go unseen.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam int NFLAG  = 6;
    localparam int REG_W  = 16;
    localparam int CTRL_W = 11;

    // flag bit positions
    localparam int FL_DRAIN = 0;
    localparam int FL_ROVF  = 1;
    localparam int FL_FILL  = 2;
    localparam int FL_TUND  = 3;
    localparam int FL_EOQ   = 4;
    localparam int FL_DONE  = 5;

    // control bit positions (bits 5:0 are request enables)
    localparam int CT_DRAIN_DMA = 6;
    localparam int CT_FILL_DMA  = 7;
    localparam int CT_OVW       = 8;
    localparam int CT_RX_ONE    = 9;
    localparam int CT_TX_ONE    = 10;
    localparam int CM_FLUSH_RX  = 11;
    localparam int CM_FLUSH_TX  = 12;

    typedef struct packed {
        logic [NFLAG-1:0]  flags;
        logic [CTRL_W-1:0] ctrl;
    } stat_regs_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         single,
    input  logic                         ovw,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full,
    output logic                         overflow,
    output logic                         underflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wr;
        logic [AW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [CW-1:0] cap;
    logic          do_pop, do_push;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] ptr_prev(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH-1) : p - 1'b1;
    endfunction

    always_comb begin
        cap       = single ? CW'(1) : CW'(DEPTH);
        empty     = (st_q.cnt == '0);
        full      = (st_q.cnt >= cap);
        do_pop    = pop && !empty;
        do_push   = push && (!full || do_pop);
        overflow  = push && full && !do_pop;
        underflow = pop && empty;
        head      = st_q.mem[st_q.rd];
        count     = st_q.cnt;

        st_d = st_q;
        if (flush) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = ptr_next(st_q.wr);
            end else if (overflow && ovw) begin
                st_d.mem[ptr_prev(st_q.wr)] = push_data;
            end
            if (do_pop) begin
                st_d.rd = ptr_next(st_q.rd);
            end
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_req_route.sv
module spi_req_route #(
    parameter int NF = 6,
    parameter int DRAIN_BIT = 0,
    parameter int FILL_BIT  = 2
) (
    input  logic [NF-1:0] flags,
    input  logic [NF-1:0] req_en,
    input  logic          drain_to_dma,
    input  logic          fill_to_dma,
    output logic          irq,
    output logic          dma_drain,
    output logic          dma_fill
);
    logic [NF-1:0] active;
    logic [NF-1:0] to_irq;

    assign active = flags & req_en;

    for (genvar i = 0; i < NF; i++) begin : g_src
        if (i == DRAIN_BIT) begin : g_drain
            assign to_irq[i] = active[i] && !drain_to_dma;
        end else if (i == FILL_BIT) begin : g_fill
            assign to_irq[i] = active[i] && !fill_to_dma;
        end else begin : g_plain
            assign to_irq[i] = active[i];
        end
    end

    assign irq       = |to_irq;
    assign dma_drain = active[DRAIN_BIT] && drain_to_dma;
    assign dma_fill  = active[FILL_BIT] && fill_to_dma;
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_push,
    input  logic [DW-1:0]    tx_push_data,
    input  logic             tx_pop,
    output logic [DW-1:0]    tx_pop_data,
    input  logic             rx_push,
    input  logic [DW-1:0]    rx_push_data,
    input  logic             rx_pop,
    output logic [DW-1:0]    rx_pop_data,
    input  logic             frame_done,
    input  logic             frame_eoq,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [NFLAG-1:0] flags,
    output logic [CNT_W-1:0] rx_count,
    output logic [CNT_W-1:0] tx_count,
    output logic             irq,
    output logic             dma_drain_req,
    output logic             dma_fill_req
);
    localparam int CW = $clog2(DEPTH+1);

    stat_regs_t    r_d, r_q;
    logic          wr_flag, wr_ctrl, flush_rx, flush_tx;
    logic [NFLAG-1:0] set_v, clr_v;
    logic [CW-1:0] rx_cnt, tx_cnt;
    logic          rx_empty, rx_full, rx_ovf, rx_unf_unused;
    logic          tx_empty_unused, tx_full, tx_ovf_unused, tx_unf;

    always_comb begin
        wr_flag  = reg_we && !reg_sel;
        wr_ctrl  = reg_we && reg_sel;
        flush_rx = wr_ctrl && reg_wdata[CM_FLUSH_RX];
        flush_tx = wr_ctrl && reg_wdata[CM_FLUSH_TX];
    end

    spi_word_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .single(r_q.ctrl[CT_RX_ONE]), .ovw(r_q.ctrl[CT_OVW]),
        .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .head(rx_pop_data), .count(rx_cnt), .empty(rx_empty), .full(rx_full),
        .overflow(rx_ovf), .underflow(rx_unf_unused)
    );

    spi_word_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .single(r_q.ctrl[CT_TX_ONE]), .ovw(1'b0),
        .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
        .head(tx_pop_data), .count(tx_cnt), .empty(tx_empty_unused), .full(tx_full),
        .overflow(tx_ovf_unused), .underflow(tx_unf)
    );

    always_comb begin
        set_v           = '0;
        set_v[FL_DRAIN] = !rx_empty;
        set_v[FL_ROVF]  = rx_ovf;
        set_v[FL_FILL]  = !tx_full;
        set_v[FL_TUND]  = tx_unf;
        set_v[FL_EOQ]   = frame_done && frame_eoq;
        set_v[FL_DONE]  = frame_done;
        clr_v           = wr_flag ? reg_wdata[NFLAG-1:0] : '0;

        r_d       = r_q;
        r_d.flags = (r_q.flags & ~clr_v) | set_v;
        if (wr_ctrl) begin
            r_d.ctrl = reg_wdata[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    spi_req_route #(.NF(NFLAG), .DRAIN_BIT(FL_DRAIN), .FILL_BIT(FL_FILL)) u_route (
        .flags(r_q.flags), .req_en(r_q.ctrl[NFLAG-1:0]),
        .drain_to_dma(r_q.ctrl[CT_DRAIN_DMA]), .fill_to_dma(r_q.ctrl[CT_FILL_DMA]),
        .irq(irq), .dma_drain(dma_drain_req), .dma_fill(dma_fill_req)
    );

    assign flags    = r_q.flags;
    assign rx_count = CNT_W'(rx_cnt);
    assign tx_count = CNT_W'(tx_cnt);
endmodule

// File: rtl/spi_fifo_status_chk.sv
module spi_fifo_status_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             tx_pop,
    input logic             rx_full,
    input logic             flush_rx,
    input logic             frame_done,
    input logic             frame_eoq,
    input logic             reg_we,
    input logic             reg_sel,
    input logic [15:0]      reg_wdata,
    input logic [10:0]      ctrl,
    input logic [5:0]       flags,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             irq,
    input logic             dma_drain_req,
    input logic             dma_fill_req
);
    a_r1_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(DEPTH));

    a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop) |=> flags[1]);

    a_r5_ovf_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_pop && !flush_rx) |=> rx_count == $past(rx_count));

    a_r7_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_count == '0) |=> flags[3]);

    a_r8_eoq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[4]) |-> $past(frame_done && frame_eoq));

    a_r4_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel && reg_wdata[5] && !frame_done) |=> !flags[5]);

    a_r10_single_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[9] && rx_count <= CNT_W'(1)) |=> rx_count <= CNT_W'(1));

    a_r11_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[5:0] == '0) |-> !(irq || dma_drain_req || dma_fill_req));

    a_r12_drain_route: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[6] |-> !dma_drain_req);

    a_r12_fill_route: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[7] |-> !dma_fill_req);
endmodule

bind spi_fifo_status spi_fifo_status_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop), .tx_pop(tx_pop),
    .rx_full(rx_full), .flush_rx(flush_rx), .frame_done(frame_done), .frame_eoq(frame_eoq),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .ctrl(r_q.ctrl),
    .flags(flags), .rx_count(rx_count), .tx_count(tx_count), .irq(irq),
    .dma_drain_req(dma_drain_req), .dma_fill_req(dma_fill_req)
);

// File: tb/sim_spi_fifo_status.sv
module sim_spi_fifo_status;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [15:0] tx_push_data = '0, rx_push_data = '0;
    logic [15:0] tx_pop_data, rx_pop_data;
    logic        frame_done = 1'b0, frame_eoq = 1'b0;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [5:0]  flags;
    logic [3:0]  rx_count, tx_count;
    logic        irq, dma_drain_req, dma_fill_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_status u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .frame_done(frame_done), .frame_eoq(frame_eoq),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .flags(flags), .rx_count(rx_count), .tx_count(tx_count),
        .irq(irq), .dma_drain_req(dma_drain_req), .dma_fill_req(dma_fill_req)
    );

    // op bits: {rx_push, rx_pop, tx_push, tx_pop}; data goes to both push ports
    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] data;
        logic [3:0]  erx;
        logic [3:0]  etx;
        logic [15:0] ehead;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'b1000, 16'hA001, 4'd1, 4'd0, 16'hA001},
        '{4'b1010, 16'hA002, 4'd2, 4'd1, 16'hA001},
        '{4'b1000, 16'hA003, 4'd3, 4'd1, 16'hA001},
        '{4'b1010, 16'hA004, 4'd4, 4'd2, 16'hA001},
        '{4'b0100, 16'h0000, 4'd3, 4'd2, 16'hA002},
        '{4'b1100, 16'hA005, 4'd3, 4'd2, 16'hA003},
        '{4'b0011, 16'hA006, 4'd3, 4'd2, 16'hA003},
        '{4'b0100, 16'h0000, 4'd2, 4'd2, 16'hA004},
        '{4'b0100, 16'h0000, 4'd1, 4'd2, 16'hA005},
        '{4'b0101, 16'h0000, 4'd0, 4'd1, 16'h0000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] v);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        tick();
        reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    task automatic rx_in(input logic [15:0] v);
        rx_push = 1'b1; rx_push_data = v;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic tx_in(input logic [15:0] v);
        tx_push = 1'b1; tx_push_data = v;
        tick();
        tx_push = 1'b0;
    endtask

    task automatic rx_take(input string req, input logic [15:0] exp);
        chk(req, "rx head", 32'(rx_pop_data), 32'(exp));
        rx_pop = 1'b1;
        tick();
        rx_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        // R1 reset state
        chk("R1", "flags in reset", 32'(flags), 32'h0);
        chk("R1", "rx_count in reset", 32'(rx_count), 32'h0);
        chk("R1", "tx_count in reset", 32'(tx_count), 32'h0);
        chk("R1", "requests in reset", 32'({irq, dma_drain_req, dma_fill_req}), 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R3", "fill after reset", 32'(flags[2]), 32'h1);
        chk("R3", "no drain when empty", 32'(flags[0]), 32'h0);

        // R1 R2 table of queue operations
        foreach (VECS[i]) begin
            rx_push = VECS[i].op[3]; rx_pop = VECS[i].op[2];
            tx_push = VECS[i].op[1]; tx_pop = VECS[i].op[0];
            rx_push_data = VECS[i].data; tx_push_data = VECS[i].data;
            tick();
            rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
            chk("R1", $sformatf("rx_count row %0d", i), 32'(rx_count), 32'(VECS[i].erx));
            chk("R1", $sformatf("tx_count row %0d", i), 32'(tx_count), 32'(VECS[i].etx));
            if (VECS[i].erx != 0)
                chk("R2", $sformatf("rx head row %0d", i), 32'(rx_pop_data), 32'(VECS[i].ehead));
        end
        chk("R2", "tx head left", 32'(tx_pop_data), 32'h0000A006);
        chk("R3", "drain and fill sticky", 32'(flags), 32'h05);

        // R4 write-1-to-clear
        wr_reg(1'b0, 16'h0001);
        chk("R4", "drain cleared, fill kept", 32'(flags), 32'h04);
        wr_reg(1'b0, 16'h0004);
        chk("R4", "fill set wins over clear", 32'(flags), 32'h04);

        // R9 transmit flush
        wr_reg(1'b1, 16'h1000);
        chk("R9", "tx flushed", 32'(tx_count), 32'h0);

        // R7 underflow
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
        chk("R7", "underflow flag", 32'(flags[3]), 32'h1);
        chk("R7", "tx count stays 0", 32'(tx_count), 32'h0);

        // R5 overflow without overwrite
        for (int k = 1; k <= 5; k++) rx_in(16'hB000 + 16'(k));
        chk("R5", "rx count at capacity", 32'(rx_count), 32'h4);
        chk("R5", "overflow flag", 32'(flags[1]), 32'h1);
        for (int k = 1; k <= 4; k++) rx_take("R5", 16'hB000 + 16'(k));
        chk("R5", "rx drained", 32'(rx_count), 32'h0);

        // R6 overwrite replaces newest entry
        wr_reg(1'b1, 16'h0100);
        wr_reg(1'b0, 16'h003F);
        for (int k = 1; k <= 5; k++) rx_in(16'hC000 + 16'(k));
        chk("R6", "overflow flag with overwrite", 32'(flags[1]), 32'h1);
        chk("R6", "rx count at capacity", 32'(rx_count), 32'h4);
        rx_take("R6", 16'hC001);
        rx_take("R6", 16'hC002);
        rx_take("R6", 16'hC003);
        rx_take("R6", 16'hC005);

        // R9 receive flush
        rx_in(16'hE001);
        rx_in(16'hE002);
        chk("R9", "rx before flush", 32'(rx_count), 32'h2);
        wr_reg(1'b1, 16'h0900);
        chk("R9", "rx flushed", 32'(rx_count), 32'h0);

        // R10 single-entry mode
        wr_reg(1'b1, 16'h0600);
        wr_reg(1'b0, 16'h003F);
        rx_in(16'hD001);
        rx_in(16'hD002);
        tx_in(16'hD003);
        tx_in(16'hD004);
        chk("R10", "rx single entry", 32'(rx_count), 32'h1);
        chk("R10", "tx single entry", 32'(tx_count), 32'h1);
        chk("R10", "rx overflow in single mode", 32'(flags[1]), 32'h1);
        chk("R10", "rx keeps first word", 32'(rx_pop_data), 32'h0000D001);
        chk("R10", "tx keeps first word", 32'(tx_pop_data), 32'h0000D003);
        wr_reg(1'b1, 16'h1800);

        // R8 frame done and end of queue
        wr_reg(1'b0, 16'h003F);
        frame_done = 1'b1; frame_eoq = 1'b0; tick(); frame_done = 1'b0;
        chk("R8", "done without eoq", 32'(flags[5:4]), 32'h2);
        frame_done = 1'b1; frame_eoq = 1'b1; tick(); frame_done = 1'b0; frame_eoq = 1'b0;
        chk("R8", "eoq set", 32'(flags[4]), 32'h1);

        // R11 R12 enables and routing
        wr_reg(1'b0, 16'h003F);
        chk("R11", "only fill set", 32'(flags), 32'h04);
        chk("R11", "no request without enable", 32'({irq, dma_drain_req, dma_fill_req}), 32'h0);
        wr_reg(1'b1, 16'h0004);
        chk("R11", "fill enabled to irq", 32'({irq, dma_drain_req, dma_fill_req}), 32'h4);
        wr_reg(1'b1, 16'h0084);
        chk("R12", "fill steered to dma", 32'({irq, dma_drain_req, dma_fill_req}), 32'h1);
        rx_in(16'hF001);
        tick();
        chk("R3", "drain one edge after data", 32'(flags[0]), 32'h1);
        wr_reg(1'b1, 16'h0041);
        chk("R12", "drain steered to dma", 32'({irq, dma_drain_req, dma_fill_req}), 32'h2);
        wr_reg(1'b1, 16'h0001);
        chk("R11", "drain enabled to irq", 32'({irq, dma_drain_req, dma_fill_req}), 32'h4);
        wr_reg(1'b1, 16'h0020);
        chk("R11", "enabled flag clear gives no irq", 32'(irq), 32'h0);
        chk("R9", "control write keeps rx data", 32'(rx_count), 32'h1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule